// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the per-sector BCH partial remainders of a t-error-correcting code over GF(2^13) into the full list of 2t syndromes a decoder needs. Software or a neighbouring block loads one 13-bit remainder word for each odd syndrome through a valid/ready write port. It then selects the correction strength and pulses start. The unit evaluates each odd syndrome bit by bit against powers of the primitive element. It forms every even syndrome by squaring a lower syndrome that is already stored, so only t evaluations are made and never 2t.

All field arithmetic is done in logic, with no lookup tables. The field is the polynomial basis over x^13 + x^4 + x^3 + x + 1. A combinational read port returns any stored syndrome by index. A done flag reports when the whole set is final.

Back-pressure rule: a remainder word transfers only on a clock edge where both `rem_valid` and `rem_ready` are high. `rem_ready` is low for the whole time a computation runs. Words offered in that time are not taken and have no effect.

Top module: `syn_expand`

## Requirements
- R1: After reset, `done` is 0, `rem_ready` is 1 and every syndrome index reads 0.
- R2: `cap_sel` selects t at start: code 0→2, 1→4, 2→8, 3→12, 4→24; codes 5, 6 and 7 select t=2.
- R3: A remainder word written at `rem_idx`=k feeds syndrome S(2k+1). Its bit j (bit 0 = LSB) carries weight alpha^((2k+1)·j mod 8191).
- R4: Each odd syndrome S(i), i=1,3,…,2t−1, is the XOR of alpha^(i·j) over the set bits j of its remainder. Elements are 13-bit polynomial-basis words (bit n = coefficient of x^n), with alpha = 13'h0002 and reduction by x^13 + x^4 + x^3 + x + 1.
- R5: Each even syndrome S(2j), j=1..t, equals S(j)·S(j) in the field. A zero S(j) gives a zero S(2j).
- R6: `done` rises exactly 14t+1 clock edges after the edge that accepts start, one cycle after the last even syndrome is written. It stays high until the next accepted start and is never high while the unit is busy.
- R7: An accepted start clears `done` and every syndrome. Indices above 2t read 0 after the run.
- R8: While busy, `rem_ready` is 0, and a start pulse or a remainder write has no effect on the timing or the results.
- R9: `rd_syn` shows syndrome S(`rd_idx`) combinationally for `rd_idx` from 1 to 48. Index 0 and indices above 48 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cap_sel | input | 3 | Correction-strength code, latched at start |
| rem_valid | input | 1 | Remainder word offered |
| rem_ready | output | 1 | Unit idle and able to take a remainder word |
| rem_idx | input | 5 | Remainder slot k (odd syndrome 2k+1) |
| rem_data | input | 13 | Remainder word |
| done | output | 1 | All 2t syndromes final |
| rd_idx | input | 6 | Syndrome index to read (1-based) |
| rd_syn | output | 13 | Syndrome value at `rd_idx` |

## Verification
A bad step register or running power inside the odd evaluation corrupts that odd syndrome. It then corrupts every even syndrome squared from it, so a single readback after `done` exposes the fault in many indices at once. A wrong phase counter moves the `done` edge away from 14t+1, and the bench catches that in the very run where it occurs. A missing clear on start leaves stale values above 2t, which show on the first short run that follows a long one.

// File: rtl/syn_exp_pkg.sv
`timescale 1ns/1ps
package syn_exp_pkg;
  localparam int GF_M = 13;
  typedef logic [GF_M-1:0] gf_t;
  // low terms of the field polynomial: x^4 + x^3 + x + 1
  localparam gf_t GF_LOW = 13'h001B;

  typedef enum logic [1:0] {ST_IDLE, ST_ODD, ST_EVEN, ST_FIN} st_e;

  // multiply by alpha (x) with reduction
  function automatic gf_t gf_xtime(gf_t a);
    return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_LOW : '0);
  endfunction

  function automatic logic [4:0] cap_decode(logic [2:0] c);
    case (c)
      3'd0:    return 5'd2;
      3'd1:    return 5'd4;
      3'd2:    return 5'd8;
      3'd3:    return 5'd12;
      3'd4:    return 5'd24;
      default: return 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/syn_gf_mult.sv
`timescale 1ns/1ps
module syn_gf_mult
  import syn_exp_pkg::*;
(
  input  gf_t a,
  input  gf_t b,
  output gf_t p
);
  // Horner-style shift and add, MSB of b first
  always_comb begin
    gf_t acc;
    acc = '0;
    for (int i = GF_M-1; i >= 0; i--) begin
      acc = gf_xtime(acc) ^ (b[i] ? a : '0);
    end
    p = acc;
  end
endmodule

// File: rtl/syn_gf_square.sv
`timescale 1ns/1ps
module syn_gf_square
  import syn_exp_pkg::*;
(
  input  gf_t a,
  output gf_t p
);
  localparam int WW = 2*GF_M - 1;

  // squaring spreads bit i to bit 2i, then folds the top half back
  always_comb begin
    logic [WW-1:0] w;
    w = '0;
    for (int i = 0; i < GF_M; i++) begin
      w[2*i] = a[i];
    end
    for (int k = WW-1; k >= GF_M; k--) begin
      if (w[k]) begin
        w[k] = 1'b0;
        w[k-GF_M +: GF_M] = w[k-GF_M +: GF_M] ^ GF_LOW;
      end
    end
    p = w[GF_M-1:0];
  end

  always_comb begin
    // a zero input never becomes a nonzero square (R5)
    p_sq_zero_r5: assert (a != '0 || p == '0);
  end
endmodule

// File: rtl/syn_store.sv
`timescale 1ns/1ps
module syn_store
  import syn_exp_pkg::*;
#(
  parameter int DEPTH = 48,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  gf_t              wdata,
  input  logic [IDX_W-1:0] ra_a,
  output gf_t              rd_a,
  input  logic [IDX_W-1:0] ra_b,
  output gf_t              rd_b
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH);

  gf_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clear) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && waddr != '0 && waddr <= LAST) begin
      mem[AW'(waddr - IDX_W'(1))] <= wdata;
    end
  end

  assign rd_a = (ra_a != '0 && ra_a <= LAST) ? mem[AW'(ra_a - IDX_W'(1))] : '0;
  assign rd_b = (ra_b != '0 && ra_b <= LAST) ? mem[AW'(ra_b - IDX_W'(1))] : '0;

  // after a clear every read returns zero (R7)
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rd_a == '0 && rd_b == '0));
endmodule

// File: rtl/syn_expand.sv
`timescale 1ns/1ps
module syn_expand
  import syn_exp_pkg::*;
#(
  parameter int MAX_T = 24,
  localparam int NSYN = 2*MAX_T,
  localparam int RI_W = $clog2(MAX_T),
  localparam int SI_W = $clog2(NSYN+1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      cap_sel,
  input  logic            rem_valid,
  output logic            rem_ready,
  input  logic [RI_W-1:0] rem_idx,
  input  logic [GF_M-1:0] rem_data,
  output logic            done,
  input  logic [SI_W-1:0] rd_idx,
  output logic [GF_M-1:0] rd_syn
);
  localparam int JW = $clog2(GF_M);

  st_e                        state;
  logic [RI_W-1:0]            k_q;
  logic [JW-1:0]              j_q;
  logic [SI_W-1:0]            e_q, t_q;
  gf_t                        beta_q, cur_q, acc_q;
  logic                       done_q;
  logic [MAX_T-1:0][GF_M-1:0] rem_q;

  gf_t             mul_out, sq_in, sq_out, acc_nx;
  logic            rbit, last_j, last_k, accept;
  logic [SI_W-1:0] t_new;
  logic [4:0]      cap_t;
  logic            st_we;
  logic [SI_W-1:0] st_waddr;
  gf_t             st_wdata;

  assign rem_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign accept    = start && (state == ST_IDLE);

  // remainder words: taken only while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else if (rem_valid && rem_ready && ({1'b0, rem_idx} < (RI_W+1)'(MAX_T)))
      rem_q[rem_idx] <= rem_data;
  end

  assign cap_t  = cap_decode(cap_sel);
  assign t_new  = (int'(cap_t) > MAX_T) ? SI_W'(MAX_T) : SI_W'(cap_t);
  assign rbit   = rem_q[k_q][j_q];
  assign acc_nx = acc_q ^ (rbit ? cur_q : '0);
  assign last_j = (j_q == JW'(GF_M-1));
  assign last_k = ((SI_W'(k_q) + SI_W'(1)) == t_q);

  syn_gf_mult u_mult (.a(cur_q), .b(beta_q), .p(mul_out));
  syn_gf_square u_sq (.a(sq_in), .p(sq_out));

  always_comb begin
    st_we    = 1'b0;
    st_waddr = '0;
    st_wdata = '0;
    case (state)
      ST_ODD: if (last_j) begin
        st_we    = 1'b1;
        st_waddr = SI_W'({k_q, 1'b1});
        st_wdata = acc_nx;
      end
      ST_EVEN: begin
        st_we    = 1'b1;
        st_waddr = SI_W'({e_q, 1'b0});
        st_wdata = sq_out;
      end
      default: ;
    endcase
  end

  syn_store #(.DEPTH(NSYN), .IDX_W(SI_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .ra_a(rd_idx), .rd_a(rd_syn),
    .ra_b(e_q), .rd_b(sq_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      k_q    <= '0;
      j_q    <= '0;
      e_q    <= '0;
      t_q    <= '0;
      beta_q <= '0;
      cur_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          t_q    <= t_new;
          k_q    <= '0;
          j_q    <= '0;
          beta_q <= gf_t'(2);
          cur_q  <= gf_t'(1);
          acc_q  <= '0;
          done_q <= 1'b0;
          state  <= ST_ODD;
        end
        ST_ODD: begin
          if (last_j) begin
            if (last_k) begin
              e_q   <= SI_W'(1);
              state <= ST_EVEN;
            end else begin
              k_q    <= k_q + RI_W'(1);
              j_q    <= '0;
              beta_q <= gf_xtime(gf_xtime(beta_q));
              cur_q  <= gf_t'(1);
              acc_q  <= '0;
            end
          end else begin
            j_q   <= j_q + JW'(1);
            cur_q <= mul_out;
            acc_q <= acc_nx;
          end
        end
        ST_EVEN: begin
          if (e_q == t_q) state <= ST_FIN;
          else            e_q   <= e_q + SI_W'(1);
        end
        ST_FIN: begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // accepted start drops done (R7)
  p_start_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done);
  // done only rises one cycle after the final even write (R6)
  p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st_we, 2) && $past(state) == ST_FIN));
  // never done while busy (R6)
  p_busy_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !done);
  // remainder words frozen while not ready (R8)
  p_rem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rem_ready |=> $stable(rem_q));
endmodule

// File: tb/tb_syn_expand.sv
`timescale 1ns/1ps
module tb_syn_expand;
  localparam int MAX_T = 24;
  localparam int NSYN  = 48;
  localparam int NV    = 6;
  localparam logic [2:0]  VCAP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
  localparam int          VT   [NV] = '{2, 4, 8, 12, 24, 2};
  localparam logic [31:0] VSEED[NV] = '{32'h1234, 32'hBEEF, 32'h0C0FFEE, 32'h5A5A5, 32'h777, 32'h2468};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, rem_valid, rem_ready, done;
  logic [2:0]  cap_sel;
  logic [4:0]  rem_idx;
  logic [12:0] rem_data, rd_syn;
  logic [5:0]  rd_idx;

  syn_expand dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_sel(cap_sel),
    .rem_valid(rem_valid), .rem_ready(rem_ready), .rem_idx(rem_idx),
    .rem_data(rem_data), .done(done), .rd_idx(rd_idx), .rd_syn(rd_syn)
  );

  int nchk = 0, nfail = 0;
  logic [12:0] remv [MAX_T];
  logic [12:0] expv [NSYN+1];
  logic [31:0] seed;

  function automatic logic [12:0] bx(logic [12:0] a);
    return {a[11:0], 1'b0} ^ (a[12] ? 13'h001B : 13'h0000);
  endfunction
  function automatic logic [12:0] bmul(logic [12:0] a, logic [12:0] b);
    logic [12:0] r, x;
    r = '0; x = a;
    for (int i = 0; i < 13; i++) begin
      if (b[i]) r = r ^ x;
      x = bx(x);
    end
    return r;
  endfunction
  function automatic logic [12:0] bpow(int e);
    logic [12:0] r;
    r = 13'h0001;
    for (int n = 0; n < e; n++) r = bx(r);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expd);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expd);
    end
  endtask

  task automatic gen_rem(input logic [31:0] s0);
    seed = s0;
    for (int k = 0; k < MAX_T; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      remv[k] = seed[28:16];
    end
  endtask

  task automatic compute_exp(input int t);
    for (int n = 0; n <= NSYN; n++) expv[n] = '0;
    for (int k = 0; k < t; k++) begin
      for (int j = 0; j < 13; j++)
        if (remv[k][j]) expv[2*k+1] = expv[2*k+1] ^ bpow(((2*k+1)*j) % 8191);
    end
    for (int j = 1; j <= t; j++) expv[2*j] = bmul(expv[j], expv[j]);
  endtask

  task automatic load_rem();
    for (int k = 0; k < MAX_T; k++) begin
      @(negedge clk);
      rem_valid = 1'b1; rem_idx = 5'(k); rem_data = remv[k];
    end
    @(negedge clk);
    rem_valid = 1'b0;
  endtask

  task automatic do_start(input logic [2:0] c);
    @(negedge clk);
    cap_sel = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_syn(input int t);
    for (int n = 0; n <= NSYN; n++) begin
      rd_idx = 6'(n);
      #0.5;
      if (n == 0)        chk(rd_syn == 13'h0, "R9 index 0", rd_syn, 0);
      else if (n > 2*t)  chk(rd_syn == 13'h0, $sformatf("R7 cleared idx %0d", n), rd_syn, 0);
      else if (n % 2)    chk(rd_syn == expv[n], $sformatf("R3/R4 odd idx %0d", n), rd_syn, expv[n]);
      else               chk(rd_syn == expv[n], $sformatf("R5 even idx %0d", n), rd_syn, expv[n]);
    end
    rd_idx = 6'd63;
    #0.5;
    chk(rd_syn == 13'h0, "R9 index 63", rd_syn, 0);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0; cap_sel = '0; rem_valid = 1'b0;
    rem_idx = '0; rem_data = '0; rd_idx = 6'd1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rem_ready == 1'b1, "R1 ready", rem_ready, 1);
    chk(rd_syn == 13'h0, "R1 syndrome", rd_syn, 0);
    rst_n = 1'b1;

    // table-driven runs
    for (int v = 0; v < NV; v++) begin
      gen_rem(VSEED[v]);
      load_rem();
      compute_exp(VT[v]);
      do_start(VCAP[v]);
      wait_done(cyc);
      chk(cyc == 14*VT[v]+1, $sformatf("R2/R6 latency code %0d", VCAP[v]), cyc, 14*VT[v]+1);
      check_syn(VT[v]);
    end

    // all-zero remainders: squares of zero stay zero
    for (int k = 0; k < MAX_T; k++) remv[k] = '0;
    load_rem();
    compute_exp(8);
    do_start(3'd2);
    wait_done(cyc);
    chk(cyc == 113, "R6 latency t=8", cyc, 113);
    check_syn(8);

    // single set bits: S(1)=alpha^12, S(3)=1, S(6)=1
    remv[0] = 13'h1000; remv[1] = 13'h0001;
    load_rem();
    compute_exp(4);
    do_start(3'd1);
    wait_done(cyc);
    rd_idx = 6'd1; #0.5;
    chk(rd_syn == 13'h1000, "R4 S1 alpha^12", rd_syn, 13'h1000);
    rd_idx = 6'd3; #0.5;
    chk(rd_syn == 13'h0001, "R4 S3 one", rd_syn, 1);
    rd_idx = 6'd6; #0.5;
    chk(rd_syn == 13'h0001, "R5 S6 one", rd_syn, 1);
    check_syn(4);

    // start and writes while busy are ignored
    gen_rem(32'hA5A5);
    load_rem();
    compute_exp(4);
    do_start(3'd1);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (cyc == 10) begin
        chk(rem_ready == 1'b0, "R8 ready low busy", rem_ready, 0);
        start = 1'b1; cap_sel = 3'd4;
        rem_valid = 1'b1; rem_idx = 5'd2; rem_data = ~remv[2];
      end
      @(negedge clk);
      start = 1'b0; rem_valid = 1'b0;
      cyc++;
    end
    chk(cyc == 57, "R8 latency unchanged", cyc, 57);
    check_syn(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule